// File: doc/BRIEF.md
# Processor Supervisor Controller

This synchronous controller supervises a processor using power-status flags that arrive already digitized. It keeps the processor in reset for a fixed number of timebase ticks after the supply becomes valid. It runs a watchdog that needs periodic activity on a strobe input. It blocks memory writes by forcing a chip-enable high whenever the supply is invalid. All timing advances only on cycles where a tick-enable input is high, which is typically a 1 kHz enable derived from the system clock.

The watchdog uses a long window for the first period after every reset, so that boot code has time to start strobing. After the first strobe transition it switches to a shorter window. A missed window sets the fault output low. The next strobe transition clears the fault and re-arms the short window. In battery-backup mode the outputs take a fixed safe pattern and the strobe is ignored.

Reset sequencer states: `RST_HOLD` and `RST_RUN`. Transitions:
- `HOLD_TO_RUN`: the reset interval has expired.
- `RUN_TO_HOLD`: the supply is invalid or backup mode is active.

Watchdog states: `WD_LONG` (first window after reset), `WD_SHORT` (normal window) and `WD_FAULT`. Transitions:
- `ARM_LONG`: any state goes to `WD_LONG` while the processor is in reset or in backup.
- `KICK`: a strobe transition moves `WD_LONG`, `WD_SHORT` or `WD_FAULT` to `WD_SHORT` and clears the count.
- `EXPIRE`: `WD_LONG` or `WD_SHORT` goes to `WD_FAULT` when its window runs out.

Top module: `cpu_supervisor`

## Requirements
- R1: While the asynchronous `por_n` input is low, `cpu_rst_n` is low and `wd_fault_n` is high.
- R2: `cpu_rst_n` goes high on the clock edge of the RST_TICKS-th tick cycle counted while `vcc_ok`=1 and `bkup_mode`=0. Cycles with `tick`=0 do not advance the count. `cpu_rst_n` returns low on the first clock edge at which the supply is invalid or backup mode is active.
- R3: `ce_gated` equals `ce_in` when `vcc_ok`=1 and `bkup_mode`=0. Otherwise it is 1, whatever `ce_in` is.
- R4: After `cpu_rst_n` rises and with no strobe activity, `wd_fault_n` falls on the WD_LONG_TICKS-th tick edge after the release edge. This long window is armed again after every reset.
- R5: Every level change of `wd_in` restarts the watchdog with the short window. With no further activity, `wd_fault_n` falls WD_SHORT_TICKS tick edges after the restart. A change of `wd_in` reaches the watchdog 3 clock edges after it is applied, through 2 synchronizer stages and an edge-detect stage.
- R6: `wd_fault_n` is active low. Once low, it stays low until the next `wd_in` transition, and it returns high 3 clock edges after that transition.
- R7: While `bkup_mode`=1, `cpu_rst_n` is low, `batt_on` is 1, `low_line_n` is 0 and `ce_gated` is 1. From the first clock edge in backup mode, `wd_fault_n` is 1 and `wd_in` activity has no effect on it.
- R8: `pf_out_n` equals `pf_cmp` while `vcc_margin_ok`=1, and is 0 while `vcc_margin_ok`=0.
- R9: `low_line_n` is 1 exactly when `vcc_ok`=1 and `bkup_mode`=0. `batt_on` equals `bkup_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tick | input | 1 | Timebase enable, one cycle per tick |
| vcc_ok | input | 1 | Supply is above the reset threshold |
| bkup_mode | input | 1 | Battery-backup mode is active |
| pf_cmp | input | 1 | Power-fail comparator result, 1 = input above threshold |
| vcc_margin_ok | input | 1 | Supply is within the margin of the battery level |
| wd_in | input | 1 | Watchdog strobe, asynchronous |
| ce_in | input | 1 | Chip-enable from the processor, active low |
| cpu_rst_n | output | 1 | Processor reset, active low |
| wd_fault_n | output | 1 | Watchdog fault, active low |
| ce_gated | output | 1 | Chip-enable passed to memory, forced high when power is invalid |
| batt_on | output | 1 | Backup mode indicator |
| low_line_n | output | 1 | Supply-valid indicator, low when the supply is invalid or in backup |
| pf_out_n | output | 1 | Power-fail warning, active low |

## Verification
The assertions assume the power-status flags are synchronous to `clk`, and that `tick` is a single-cycle enable. Only `wd_in` may change at any time. The bench drives every input on the falling edge, so the flags are stable at each rising edge. It holds `tick` at 1 during the timing tests, and at 0 only to show that the timers stop. Strobe changes are spaced further apart than the 3-cycle detection latency, so no transition is lost in the synchronizer.

// File: rtl/supv_pkg.sv
package supv_pkg;
    typedef enum logic {
        RST_HOLD = 1'b0,
        RST_RUN  = 1'b1
    } rst_state_t;

    typedef enum logic [1:0] {
        WD_LONG  = 2'd0,
        WD_SHORT = 2'd1,
        WD_FAULT = 2'd2
    } wd_state_t;
endpackage

// File: rtl/supv_edge_sync.sv
module supv_edge_sync (
    input  logic clk,
    input  logic por_n,
    input  logic async_in,
    output logic toggled
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign toggled = sync_q ^ prev_q;
endmodule

// File: rtl/supv_reset_seq.sv
module supv_reset_seq
    import supv_pkg::*;
#(
    parameter int RST_TICKS = 200
) (
    input  logic clk,
    input  logic por_n,
    input  logic tick,
    input  logic power_good,
    output logic run
);
    localparam int CW = $clog2(RST_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(RST_TICKS - 1);

    rst_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RST_HOLD: begin
                if (!power_good) begin
                    cnt_d = '0;
                end else if (tick) begin
                    if (cnt_q == LAST) begin
                        state_d = RST_RUN;      // HOLD_TO_RUN
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            RST_RUN: begin
                if (!power_good) begin
                    state_d = RST_HOLD;         // RUN_TO_HOLD
                    cnt_d   = '0;
                end
            end
            default: state_d = RST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= RST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb run = (state_q == RST_RUN);

    AST_RST_DROP_ON_BAD_POWER: assert property (@(posedge clk) disable iff (!por_n)
        !power_good |=> state_q == RST_HOLD);                                   // R2
    AST_RST_CNT_BOUND: assert property (@(posedge clk) disable iff (!por_n)
        cnt_q < CW'(RST_TICKS));                                                 // R2
    AST_RST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!por_n)
        $rose(run) |-> $past(tick) && $past(power_good));                        // R2
endmodule

// File: rtl/supv_watchdog.sv
module supv_watchdog
    import supv_pkg::*;
#(
    parameter int WD_SHORT_TICKS = 100,
    parameter int WD_LONG_TICKS  = 1600
) (
    input  logic clk,
    input  logic por_n,
    input  logic tick,
    input  logic enable,
    input  logic kick,
    output logic fault_n
);
    localparam int MAXT = (WD_LONG_TICKS > WD_SHORT_TICKS) ? WD_LONG_TICKS : WD_SHORT_TICKS;
    localparam int CW   = $clog2(MAXT + 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(WD_LONG_TICKS - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(WD_SHORT_TICKS - 1);

    wd_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] limit;

    always_comb limit = (state_q == WD_LONG) ? LONG_LAST : SHORT_LAST;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!enable) begin
            state_d = WD_LONG;                  // ARM_LONG
            cnt_d   = '0;
        end else if (kick) begin
            state_d = WD_SHORT;                 // KICK
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                WD_LONG, WD_SHORT: begin
                    if (tick) begin
                        if (cnt_q == limit) begin
                            state_d = WD_FAULT; // EXPIRE
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                WD_FAULT: cnt_d = '0;
                default:  state_d = WD_LONG;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= WD_LONG;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb fault_n = (state_q != WD_FAULT);

    AST_WD_HELD_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!por_n)
        !enable |=> fault_n && state_q == WD_LONG);                              // R7
    AST_WD_KICK_RESTARTS: assert property (@(posedge clk) disable iff (!por_n)
        (enable && kick) |=> state_q == WD_SHORT && cnt_q == '0);                // R5
    AST_WD_FAULT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!por_n)
        $fell(fault_n) |-> $past(tick) && $past(enable));                        // R4
    AST_WD_FAULT_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        (!fault_n && enable && !kick) |=> !fault_n);                             // R6
endmodule

// File: rtl/cpu_supervisor.sv
module cpu_supervisor #(
    parameter int RST_TICKS      = 200,
    parameter int WD_SHORT_TICKS = 100,
    parameter int WD_LONG_TICKS  = 1600
) (
    input  logic clk,
    input  logic por_n,
    input  logic tick,
    input  logic vcc_ok,
    input  logic bkup_mode,
    input  logic pf_cmp,
    input  logic vcc_margin_ok,
    input  logic wd_in,
    input  logic ce_in,
    output logic cpu_rst_n,
    output logic wd_fault_n,
    output logic ce_gated,
    output logic batt_on,
    output logic low_line_n,
    output logic pf_out_n
);
    logic power_good;
    logic run;
    logic kick;

    always_comb power_good = vcc_ok && !bkup_mode;

    supv_edge_sync i_sync (
        .clk      (clk),
        .por_n    (por_n),
        .async_in (wd_in),
        .toggled  (kick)
    );

    supv_reset_seq #(.RST_TICKS(RST_TICKS)) i_rst (
        .clk        (clk),
        .por_n      (por_n),
        .tick       (tick),
        .power_good (power_good),
        .run        (run)
    );

    supv_watchdog #(
        .WD_SHORT_TICKS (WD_SHORT_TICKS),
        .WD_LONG_TICKS  (WD_LONG_TICKS)
    ) i_wd (
        .clk     (clk),
        .por_n   (por_n),
        .tick    (tick),
        .enable  (run && !bkup_mode),
        .kick    (kick),
        .fault_n (wd_fault_n)
    );

    always_comb begin
        cpu_rst_n  = run;
        ce_gated   = power_good ? ce_in : 1'b1;
        batt_on    = bkup_mode;
        low_line_n = power_good;
        pf_out_n   = vcc_margin_ok && pf_cmp;
    end

    AST_BKUP_PATTERN: assert property (@(posedge clk) disable iff (!por_n)
        bkup_mode |=> !cpu_rst_n && wd_fault_n);                                 // R7
    AST_CE_BLOCKED: assert property (@(posedge clk) disable iff (!por_n)
        !vcc_ok |-> ce_gated);                                                   // R3
    AST_PF_FORCED: assert property (@(posedge clk) disable iff (!por_n)
        !vcc_margin_ok |-> !pf_out_n);                                           // R8
    AST_RUN_NEEDS_POWER: assert property (@(posedge clk) disable iff (!por_n)
        cpu_rst_n |-> $past(power_good));                                        // R2
endmodule

// File: tb/test_cpu_supervisor.sv
module test_cpu_supervisor;
    localparam int RT = 8;
    localparam int ST = 5;
    localparam int LT = 20;

    logic clk = 1'b0;
    logic por_n, tick, vcc_ok, bkup_mode, pf_cmp, vcc_margin_ok, wd_in, ce_in;
    logic cpu_rst_n, wd_fault_n, ce_gated, batt_on, low_line_n, pf_out_n;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    cpu_supervisor #(
        .RST_TICKS(RT), .WD_SHORT_TICKS(ST), .WD_LONG_TICKS(LT)
    ) i_cpu_supervisor (
        .clk(clk), .por_n(por_n), .tick(tick), .vcc_ok(vcc_ok),
        .bkup_mode(bkup_mode), .pf_cmp(pf_cmp), .vcc_margin_ok(vcc_margin_ok),
        .wd_in(wd_in), .ce_in(ce_in), .cpu_rst_n(cpu_rst_n),
        .wd_fault_n(wd_fault_n), .ce_gated(ce_gated), .batt_on(batt_on),
        .low_line_n(low_line_n), .pf_out_n(pf_out_n)
    );

    // {vcc_ok, bkup, margin, pf_cmp, ce_in, exp_ce, exp_pf, exp_batt, exp_low}
    localparam int NV = 8;
    localparam logic [8:0] VEC [NV] = '{
        9'b1_0_1_1_0_0_1_0_1,
        9'b1_0_1_0_1_1_0_0_1,
        9'b0_0_1_1_0_1_1_0_0,
        9'b0_0_0_1_1_1_0_0_0,
        9'b1_0_0_1_0_0_0_0_1,
        9'b1_1_1_1_0_1_1_1_0,
        9'b0_1_0_0_0_1_0_1_0,
        9'b1_0_1_1_1_1_1_0_1
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        por_n = 1'b0; tick = 1'b1; vcc_ok = 1'b0; bkup_mode = 1'b0;
        pf_cmp = 1'b1; vcc_margin_ok = 1'b1; wd_in = 1'b0; ce_in = 1'b0;
        adv(3);
        chk("R1 cpu_rst_n", cpu_rst_n, 1'b0);
        chk("R1 wd_fault_n", wd_fault_n, 1'b1);

        // combinational gating table (R3 R8 R9)
        for (int i = 0; i < NV; i++) begin
            {vcc_ok, bkup_mode, vcc_margin_ok, pf_cmp, ce_in} = VEC[i][8:4];
            #1;
            chk("R3 ce_gated", ce_gated, VEC[i][3]);
            chk("R8 pf_out_n", pf_out_n, VEC[i][2]);
            chk("R9 batt_on", batt_on, VEC[i][1]);
            chk("R9 low_line_n", low_line_n, VEC[i][0]);
        end
        adv(1);

        // R2: reset interval, ticks gate the count
        vcc_ok = 1'b1; bkup_mode = 1'b0; vcc_margin_ok = 1'b1; ce_in = 1'b0;
        tick = 1'b0; por_n = 1'b1;
        adv(30);
        chk("R2 no tick no release", cpu_rst_n, 1'b0);
        tick = 1'b1;
        adv(RT - 1);
        chk("R2 still in reset", cpu_rst_n, 1'b0);
        adv(1);
        chk("R2 released", cpu_rst_n, 1'b1);

        // R4: long first window
        adv(LT - 1);
        chk("R4 before long expiry", wd_fault_n, 1'b1);
        adv(1);
        chk("R4 long expiry", wd_fault_n, 1'b0);

        // R6: clear on next transition
        wd_in = ~wd_in;
        adv(2);
        chk("R6 fault held during sync", wd_fault_n, 1'b0);
        adv(1);
        chk("R6 fault cleared", wd_fault_n, 1'b1);

        // R5: short window
        adv(ST - 1);
        chk("R5 before short expiry", wd_fault_n, 1'b1);
        adv(1);
        chk("R5 short expiry", wd_fault_n, 1'b0);

        // R5: keep-alive strobing prevents fault
        wd_in = ~wd_in;
        adv(3);
        for (int k = 0; k < 6; k++) begin
            wd_in = ~wd_in;
            adv(3);
            chk("R5 strobed no fault", wd_fault_n, 1'b1);
        end

        // R2/R3: supply loss
        vcc_ok = 1'b0;
        adv(1);
        chk("R2 reasserted on supply loss", cpu_rst_n, 1'b0);
        chk("R3 ce forced high", ce_gated, 1'b1);

        // R7: backup pattern, strobe ignored
        vcc_ok = 1'b1; bkup_mode = 1'b1;
        adv(1);
        chk("R7 cpu_rst_n", cpu_rst_n, 1'b0);
        chk("R7 wd_fault_n", wd_fault_n, 1'b1);
        chk("R7 batt_on", batt_on, 1'b1);
        chk("R7 low_line_n", low_line_n, 1'b0);
        chk("R7 ce_gated", ce_gated, 1'b1);
        for (int k = 0; k < 5; k++) begin
            wd_in = ~wd_in;
            adv(5);
        end
        adv(LT);
        chk("R7 strobe ignored", wd_fault_n, 1'b1);
        chk("R7 reset held", cpu_rst_n, 1'b0);

        // leave backup: new reset interval, long window re-armed
        bkup_mode = 1'b0;
        adv(RT - 1);
        chk("R2 reset after backup", cpu_rst_n, 1'b0);
        adv(1);
        chk("R2 release after backup", cpu_rst_n, 1'b1);
        adv(LT - 1);
        chk("R4 long rearmed", wd_fault_n, 1'b1);
        adv(1);
        chk("R4 long rearmed expiry", wd_fault_n, 1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule